// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

This block chooses which of several interrupt sources the processor takes next. Each source has a pending flag, a 4-bit priority (1 to 15, with 0 meaning the source is switched off) and a 2-bit tie-break rank within that priority. Each cycle the block finds the pending, enabled source with the largest {priority, rank} pair. It offers that source only when its priority is strictly above the processor's current level and no atomic lockout is running.

The winning source leaves the block on a valid/ready stream. `irq_valid` or `evt_valid` is the valid, `win_idx` is the payload and `win_ready` is the back-pressure. A transfer takes place on a clock edge where a valid is high and `win_ready` is high. While `win_ready` is low, the block keeps every pending flag and the processor level unchanged. The offer itself is not frozen: a newly arriving, stronger request may replace it before it is taken.

A taken ordinary interrupt clears its pending flag and raises the processor level to the winner's priority, so members of the same priority cannot preempt each other. Priorities at or above 13 are reserved for data-transfer channels. Those wins appear on `evt_valid`, clear their pending flag and leave the processor level alone. An atomic command blocks every offer for the next 1 to 4 retired instructions. The offers then resume without any further action from software.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset all pending flags, source settings, the processor level and the lockout count are zero, so neither valid output is high.
- R2: A high bit of `req_set` at a clock edge makes that source pending. The flag stays set until that source is transferred, and a set in the same cycle as its transfer leaves it pending.
- R3: A source whose priority is 0 is never offered, whatever the processor level.
- R4: A source is offered only when its priority is strictly greater than `cpu_lvl`. A source at or below the level stays pending and is not offered.
- R5: The offered source is the pending, enabled source with the largest value of {priority, rank}, with priority in the upper bits. On an exact tie the lower source index wins.
- R6: A transferred ordinary interrupt (`irq_valid` and `win_ready` both high) clears its pending flag at that edge. The same edge loads `cpu_lvl` with its priority.
- R7: `cpu_we` loads `cpu_lvl` with `cpu_wdata` at the next edge, and the new level masks at once from that cycle on. A write in the same cycle as a transfer takes precedence over the transfer's load.
- R8: `atomic_go` loads the lockout count with `atomic_len`+1 (1 to 4). Each `insn_retire` lowers a nonzero count by one, and no offer is made while the count is nonzero. A load in the same cycle as a retire wins. Blocking starts in the cycle after `atomic_go`.
- R9: A winner with priority of 13 or more is offered on `evt_valid` instead of `irq_valid`, and the two are never high together. Its transfer clears its pending flag and leaves `cpu_lvl` unchanged.
- R10: While `win_ready` is low, no pending flag is cleared and `cpu_lvl` changes only by `cpu_we`.
- R11: A write with `cfg_we` stores `cfg_lvl` and `cfg_grp` for source `cfg_idx`. The arbitration uses the new setting from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_set | input | NUM_SRC | Per-source set pulses for the pending flags |
| cfg_we | input | 1 | Source setting write strobe |
| cfg_idx | input | IDX_W | Source written by `cfg_we` |
| cfg_lvl | input | LVL_W | Priority to store (0 disables) |
| cfg_grp | input | GRP_W | Rank within the priority |
| cpu_we | input | 1 | Processor level write strobe |
| cpu_wdata | input | LVL_W | New processor level |
| cpu_lvl | output | LVL_W | Current processor level |
| atomic_go | input | 1 | Start or restart an atomic lockout |
| atomic_len | input | LEN_W | Lockout length minus one |
| insn_retire | input | 1 | One instruction retired |
| win_ready | input | 1 | Consumer takes the offered source |
| irq_valid | output | 1 | Ordinary interrupt offered |
| evt_valid | output | 1 | Data-transfer channel offered |
| win_idx | output | IDX_W | Index of the offered source |

## Verification
The bench first fires two sources at one priority with different ranks, and then two sources with identical settings, which separates rank-based ordering from index-based tie-breaking. It holds `win_ready` low for several cycles to show that a stalled offer changes neither flags nor level. Accepting at a level equal to a remaining source shows that the comparison is strict. A level write that coincides with a transfer shows which of the two sets the level. Lockout lengths, retire pulses, disabled sources and reserved priorities are then mixed in a long random run, where a behavioural model checks every cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int DEF_NUM_SRC = 8;
  localparam int DEF_LVL_W   = 4;
  localparam int DEF_GRP_W   = 2;
  localparam int DEF_LEN_W   = 2;
  localparam int DEF_EVT_LVL = 13;
endpackage

// File: rtl/irq_src_cfg.sv
module irq_src_cfg #(
  parameter int NUM_SRC = irq_arb_pkg::DEF_NUM_SRC,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  parameter int GRP_W   = irq_arb_pkg::DEF_GRP_W,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [LVL_W-1:0]         cfg_lvl,
  input  logic [GRP_W-1:0]         cfg_grp,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic [NUM_SRC*GRP_W-1:0] grp_flat
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [LVL_W-1:0] lvl_q;
    logic [GRP_W-1:0] grp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= '0;
        grp_q <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
        lvl_q <= cfg_lvl;
        grp_q <= cfg_grp;
      end
    end
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
    assign grp_flat[i*GRP_W +: GRP_W] = grp_q;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_SRC = irq_arb_pkg::DEF_NUM_SRC,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  parameter int GRP_W   = irq_arb_pkg::DEF_GRP_W,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int KEY_W  = LVL_W + GRP_W
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic [NUM_SRC*GRP_W-1:0] grp_flat,
  output logic                     hit,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  logic [KEY_W-1:0] best_key;
  logic [KEY_W-1:0] cand;
  logic [LVL_W-1:0] cand_lvl;

  // Ascending scan with strict compare: ties keep the lower index.
  always_comb begin
    hit      = 1'b0;
    win_idx  = '0;
    best_key = '0;
    cand     = '0;
    cand_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      cand_lvl = lvl_flat[i*LVL_W +: LVL_W];
      cand     = {cand_lvl, grp_flat[i*GRP_W +: GRP_W]};
      if (pend[i] && cand_lvl != '0 && (!hit || cand > best_key)) begin
        hit      = 1'b1;
        best_key = cand;
        win_idx  = IDX_W'(i);
      end
    end
  end

  assign win_lvl = best_key[KEY_W-1:GRP_W];
endmodule

// File: rtl/irq_lockout.sv
module irq_lockout #(
  parameter int LEN_W  = irq_arb_pkg::DEF_LEN_W,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             atomic_go,
  input  logic [LEN_W-1:0] atomic_len,
  input  logic             insn_retire,
  output logic [CNT_W-1:0] lock_cnt,
  output logic             lock_busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_cnt <= '0;
    else if (atomic_go)
      lock_cnt <= CNT_W'(atomic_len) + CNT_W'(1);
    else if (insn_retire && lock_cnt != '0)
      lock_cnt <= lock_cnt - CNT_W'(1);
  end

  assign lock_busy = (lock_cnt != '0);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NUM_SRC = irq_arb_pkg::DEF_NUM_SRC,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  parameter int GRP_W   = irq_arb_pkg::DEF_GRP_W,
  parameter int LEN_W   = irq_arb_pkg::DEF_LEN_W,
  parameter int EVT_LVL = irq_arb_pkg::DEF_EVT_LVL,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_set,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [LVL_W-1:0]   cfg_lvl,
  input  logic [GRP_W-1:0]   cfg_grp,
  input  logic               cpu_we,
  input  logic [LVL_W-1:0]   cpu_wdata,
  output logic [LVL_W-1:0]   cpu_lvl,
  input  logic               atomic_go,
  input  logic [LEN_W-1:0]   atomic_len,
  input  logic               insn_retire,
  input  logic               win_ready,
  output logic               irq_valid,
  output logic               evt_valid,
  output logic [IDX_W-1:0]   win_idx
);
  localparam int CNT_W = LEN_W + 1;

  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic [NUM_SRC*GRP_W-1:0] grp_flat;
  logic [NUM_SRC-1:0]       pend_q;
  logic [NUM_SRC-1:0]       clr_mask;
  logic [LVL_W-1:0]         cpu_lvl_q;
  logic [LVL_W-1:0]         win_lvl;
  logic [CNT_W-1:0]         lock_cnt;
  logic                     lock_busy;
  logic                     hit;
  logic                     offer;
  logic                     is_evt;
  logic                     xfer;

  irq_src_cfg #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lvl(cfg_lvl), .cfg_grp(cfg_grp),
    .lvl_flat(lvl_flat), .grp_flat(grp_flat)
  );

  irq_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W)) u_pick (
    .pend(pend_q), .lvl_flat(lvl_flat), .grp_flat(grp_flat),
    .hit(hit), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_lockout #(.LEN_W(LEN_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .atomic_go(atomic_go), .atomic_len(atomic_len),
    .insn_retire(insn_retire), .lock_cnt(lock_cnt), .lock_busy(lock_busy)
  );

  assign offer     = hit && (win_lvl > cpu_lvl_q) && !lock_busy;
  assign is_evt    = (win_lvl >= LVL_W'(EVT_LVL));
  assign irq_valid = offer && !is_evt;
  assign evt_valid = offer && is_evt;
  assign xfer      = offer && win_ready;
  assign clr_mask  = xfer ? (NUM_SRC'(1) << win_idx) : '0;
  assign cpu_lvl   = cpu_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cpu_lvl_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | req_set;
      if (cpu_we)
        cpu_lvl_q <= cpu_wdata;
      else if (xfer && !is_evt)
        cpu_lvl_q <= win_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int LVL_W = 4,
  parameter int LEN_W = 2,
  localparam int CNT_W = LEN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             evt_valid,
  input logic             win_ready,
  input logic             cpu_we,
  input logic [LVL_W-1:0] cpu_wdata,
  input logic [LVL_W-1:0] cpu_lvl,
  input logic [LVL_W-1:0] win_lvl,
  input logic             atomic_go,
  input logic [LEN_W-1:0] atomic_len,
  input logic             insn_retire,
  input logic [CNT_W-1:0] lock_cnt
);
  AST_LVL_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid || evt_valid) |-> win_lvl != '0); // R3
  AST_STRICT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid || evt_valid) |-> win_lvl > cpu_lvl); // R4
  AST_TAKE_LOADS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && win_ready && !cpu_we) |=> cpu_lvl == $past(win_lvl)); // R6
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> cpu_lvl == $past(cpu_wdata)); // R7
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != '0) |-> !(irq_valid || evt_valid)); // R8
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    atomic_go |=> lock_cnt == CNT_W'($past(atomic_len)) + CNT_W'(1)); // R8
  AST_LOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!atomic_go && insn_retire && lock_cnt != '0) |=> lock_cnt == $past(lock_cnt) - CNT_W'(1)); // R8
  AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_valid, evt_valid})); // R9
  AST_EVT_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && win_ready && !cpu_we) |=> $stable(cpu_lvl)); // R9
  AST_STALL_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_ready && !cpu_we) |=> $stable(cpu_lvl)); // R10
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.LVL_W(LVL_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .evt_valid(evt_valid),
  .win_ready(win_ready), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
  .cpu_lvl(cpu_lvl), .win_lvl(win_lvl), .atomic_go(atomic_go),
  .atomic_len(atomic_len), .insn_retire(insn_retire), .lock_cnt(lock_cnt)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_set = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [3:0] cfg_lvl = '0;
  logic [1:0] cfg_grp = '0;
  logic cpu_we = 1'b0;
  logic [3:0] cpu_wdata = '0;
  logic [3:0] cpu_lvl;
  logic atomic_go = 1'b0;
  logic [1:0] atomic_len = '0;
  logic insn_retire = 1'b0;
  logic win_ready = 1'b0;
  logic irq_valid, evt_valid;
  logic [2:0] win_idx;

  int total = 0, bad = 0, cycles = 0;
  int m_lvl[N], m_grp[N], m_pend[N];
  int m_cpu = 0, m_lock = 0;

  always #2 clk = ~clk;

  irq_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cfg_grp(cfg_grp),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_lvl(cpu_lvl),
    .atomic_go(atomic_go), .atomic_len(atomic_len), .insn_retire(insn_retire),
    .win_ready(win_ready), .irq_valid(irq_valid), .evt_valid(evt_valid),
    .win_idx(win_idx)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Model offer computed from model state only.
  function automatic void model_offer(output int v, output int e, output int idx, output int lvl);
    int best = -1;
    idx = 0; lvl = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] != 0 && m_lvl[i] != 0 && m_lvl[i]*4 + m_grp[i] > best) begin
        best = m_lvl[i]*4 + m_grp[i]; idx = i; lvl = m_lvl[i];
      end
    v = (best >= 0 && lvl > m_cpu && m_lock == 0) ? 1 : 0;
    e = (v != 0 && lvl >= 13) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_grp[i] = 0; m_pend[i] = 0; end
      m_cpu = 0; m_lock = 0;
    end else begin
      int v, e, idx, lvl;
      model_offer(v, e, idx, lvl);
      if (v != 0 && win_ready) m_pend[idx] = 0;
      for (int i = 0; i < N; i++) if (req_set[i]) m_pend[i] = 1;
      if (cpu_we) m_cpu = cpu_wdata;
      else if (v != 0 && e == 0 && win_ready) m_cpu = lvl;
      if (cfg_we) begin m_lvl[cfg_idx] = cfg_lvl; m_grp[cfg_idx] = cfg_grp; end
      if (atomic_go) m_lock = atomic_len + 1;
      else if (insn_retire && m_lock > 0) m_lock = m_lock - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int v, e, idx, lvl;
      model_offer(v, e, idx, lvl);
      chk("R4 irq_valid vs model", int'(irq_valid), (v != 0 && e == 0) ? 1 : 0);
      chk("R9 evt_valid vs model", int'(evt_valid), e);
      if (v != 0) chk("R5 win_idx vs model", int'(win_idx), idx);
      chk("R6 cpu_lvl vs model", int'(cpu_lvl), m_cpu);
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
    req_set = '0; cfg_we = 0; cpu_we = 0; atomic_go = 0; insn_retire = 0;
  endtask

  task automatic cfg(int idx, int lvl, int grp);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_lvl = 4'(lvl); cfg_grp = 2'(grp);
    step();
  endtask

  task automatic expect_out(string tag, int iv, int ev, int idx, int lvl);
    chk({tag, " irq_valid"}, int'(irq_valid), iv);
    chk({tag, " evt_valid"}, int'(evt_valid), ev);
    if (iv != 0 || ev != 0) chk({tag, " win_idx"}, int'(win_idx), idx);
    chk({tag, " cpu_lvl"}, int'(cpu_lvl), lvl);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step();
    expect_out("R1", 0, 0, 0, 0);
    cfg(1, 5, 1); cfg(4, 5, 2); cfg(3, 7, 0); cfg(6, 7, 0); cfg(7, 14, 0); cfg(2, 0, 3);
    req_set = 8'h04; step();
    expect_out("R3", 0, 0, 0, 0);
    req_set = 8'h12; step();
    expect_out("R5 rank", 1, 0, 4, 0);
    step(); step();
    expect_out("R10 stall", 1, 0, 4, 0);
    win_ready = 1; step(); win_ready = 0;
    expect_out("R6 take", 0, 0, 0, 5);          // src1 at 5 is not above 5: R4
    cpu_we = 1; cpu_wdata = 4; step();
    expect_out("R7 lower", 1, 0, 1, 4);         // src1 still pending: R2
    req_set = 8'h48; step();
    expect_out("R5 tie", 1, 0, 3, 4);
    win_ready = 1; step(); win_ready = 0;
    expect_out("R4 equal", 0, 0, 0, 7);
    cpu_we = 1; cpu_wdata = 3; step();
    expect_out("R7 write", 1, 0, 6, 3);
    win_ready = 1; cpu_we = 1; cpu_wdata = 2; step(); win_ready = 0;
    expect_out("R7 wins", 1, 0, 1, 2);
    atomic_go = 1; atomic_len = 1; step();
    expect_out("R8 locked", 0, 0, 0, 2);
    insn_retire = 1; step();
    expect_out("R8 one left", 0, 0, 0, 2);
    insn_retire = 1; step();
    expect_out("R8 released", 1, 0, 1, 2);
    req_set = 8'h80; step();
    expect_out("R9 event", 0, 1, 7, 2);
    win_ready = 1; step(); win_ready = 0;
    expect_out("R9 after", 1, 0, 1, 2);
    cfg(1, 0, 0);
    expect_out("R11 disabled", 0, 0, 0, 2);
    for (int k = 0; k < 4000; k++) begin
      req_set = ($urandom_range(0, 3) == 0) ? 8'($urandom) : '0;
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_idx = 3'($urandom); cfg_lvl = 4'($urandom); cfg_grp = 2'($urandom);
      cpu_we = ($urandom_range(0, 5) == 0);
      cpu_wdata = 4'($urandom_range(0, 9));
      atomic_go = ($urandom_range(0, 19) == 0);
      atomic_len = 2'($urandom);
      insn_retire = ($urandom_range(0, 1) == 0);
      win_ready = ($urandom_range(0, 1) == 0);
      @(negedge clk);
    end
    finish_run();
  end
endmodule